// File: doc/BRIEF.md
# Three-Pair Compare PWM Generator

This block drives three complementary PWM channel pairs, six outputs in all, from one register write port. Each pair owns a 16-bit up-counter that steps on a shared prescaled tick, counts from zero to that pair's length value and then returns to zero. Three compare values per pair place the edges. The high-side output is set by the first compare and cleared by the second. The low-side output is set when the counter reaches the length value. It is cleared by the third compare, or in the same cycle that the high side falls, whichever comes first.

Software writes a control word that holds the prescale ratio, a mode bit and an enable bit. Compare and length values go to shadow registers. While the pairs run, these values reach the comparators only at the pair's next period end. While the pairs are stopped, they are taken at once. After reset the block sits in its safe bridge mode with every output low. It produces no pulses until software selects standard mode and sets the enable bit. Every period end sets one shared interrupt flag, which stays set until software writes the clear address.

Top module: `pwm_pair_gen`

## Requirements
- R1: After reset the control word is zero (bridge mode, disabled, prescale select 0), all six outputs are low and irq is low.
- R2: All six outputs are held low unless the control word has enable (bit 4) set and the mode bit (bit 3) at 1 (standard); mode bit 0 is the safe bridge mode.
- R3: The counter advances once every 2^(sel+1) clocks, where sel is control bits [2:0], so a pair's period is (len+1)*2^(sel+1) clocks.
- R4: The high side rises when the counter equals compare 0 and falls when it equals compare 1, so for compare 0 < compare 1 <= len it stays high for (compare 1 - compare 0)*2^(sel+1) clocks.
- R5: The low side rises when the counter equals len and falls when it equals compare 2, so with no earlier high-side fall it stays high for (compare 2 + 1)*2^(sel+1) clocks.
- R6: If the high side falls while the low side is high, the low side falls in the same clock cycle.
- R7: Compare and length writes made while running take effect only after the pair's next wrap to zero; writes made while stopped apply before the next start.
- R8: irq is set by the wrap of any pair, stays set without a clear, and drops in the cycle after a write to the clear address when no wrap coincides.
- R9: Each pair keeps its own period and compares; the waveform of one pair does not depend on the settings of another.
- R10: Address map: 0 is control; pair p uses 1+4p (compare 0), 2+4p (compare 1), 3+4p (compare 2) and 4+4p (length); 13 clears irq; writes to 14 and 15 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the prescaler source |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 16 | Register write data |
| pwm_hi | output | 3 | High-side output of each pair |
| pwm_lo | output | 3 | Low-side output of each pair |
| irq | output | 1 | Sticky period-end interrupt flag |

## Verification
The bound checker checks four rules on every cycle: outputs stay low while the block is idle, the low side never outlives a high-side fall, irq holds until it is cleared and drops after a clear, and irq rises only after a wrap. Quantities that span many cycles cannot be expressed as short properties, so the bench scenarios measure them from the output edges. These are the prescaled period, the pulse widths set by each compare, the deferral of shadow writes to the wrap, and the independence of the pairs.

// File: rtl/pwm_pair_pkg.sv
`timescale 1ns/1ps
package pwm_pair_pkg;

   // Operating mode held in the control word; zero is the safe state
   typedef enum logic {
      MODE_BRIDGE   = 1'b0,
      MODE_STANDARD = 1'b1
   } pwm_mode_e;

   // Control word image, packed to match its bit layout (en=4, mode=3, sel=2:0)
   typedef struct packed {
      logic      en;
      pwm_mode_e mode;
      logic [2:0] sel;
   } pwm_ctrl_t;

   localparam int CTRL_BITS = $bits(pwm_ctrl_t);

   // Per-pair register slots, in address order
   typedef enum logic [1:0] {
      FLD_RISE = 2'd0,
      FLD_FALL = 2'd1,
      FLD_LOFF = 2'd2,
      FLD_LEN  = 2'd3
   } pwm_field_e;

   localparam int FIELDS_PER_PAIR = 4;

endpackage

// File: rtl/pwm_prescaler.sv
`timescale 1ns/1ps
module pwm_prescaler #(
   parameter int SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);
   localparam int PRE_W = 1 << SEL_W;

   generate
      if (SEL_W < 1 || SEL_W > 4) begin : g_bad_sel
         $error("pwm_prescaler: SEL_W must lie in 1..4");
      end
   endgenerate

   logic [PRE_W-1:0] pre_cnt;
   logic [PRE_W-1:0] mask;

   // Ratio 2^(sel+1): the low sel+1 bits of the free counter must all be ones
   always_comb begin
      for (int i = 0; i < PRE_W; i++) begin
         mask[i] = (i <= int'(sel));
      end
   end

   assign tick = run && ((pre_cnt & mask) == mask);

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         pre_cnt <= '0;
      end else begin
         pre_cnt <= pre_cnt + 1'b1;
      end
   end

endmodule

// File: rtl/pwm_pair_core.sv
`timescale 1ns/1ps
module pwm_pair_core
   import pwm_pair_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       run,
   input  logic                       tick,
   input  logic [FIELDS_PER_PAIR-1:0] fld_we,
   input  logic [CNT_W-1:0]           wr_data,
   output logic                       hi,
   output logic                       lo,
   output logic                       wrap
);
   logic [CNT_W-1:0] shd [FIELDS_PER_PAIR];
   logic [CNT_W-1:0] act [FIELDS_PER_PAIR];
   logic [CNT_W-1:0] cnt;
   logic             load;

   assign wrap = tick && (cnt == act[FLD_LEN]);
   assign load = !run || wrap;

   // Shadow and active copies of each field
   genvar f;
   generate
      for (f = 0; f < FIELDS_PER_PAIR; f++) begin : g_fld
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               shd[f] <= '0;
               act[f] <= '0;
            end else begin
               if (fld_we[f]) shd[f] <= wr_data;
               if (load)      act[f] <= shd[f];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         cnt <= '0;
      end else if (wrap) begin
         cnt <= '0;
      end else if (tick) begin
         cnt <= cnt + 1'b1;
      end
   end

   logic hit_rise, hit_fall, hit_loff, hit_len;
   logic hi_nxt, lo_nxt, hi_drop;

   assign hit_rise = (cnt == act[FLD_RISE]);
   assign hit_fall = (cnt == act[FLD_FALL]);
   assign hit_loff = (cnt == act[FLD_LOFF]);
   assign hit_len  = (cnt == act[FLD_LEN]);

   // Clearing beats setting on both sides
   always_comb begin
      hi_nxt  = hit_fall ? 1'b0 : (hit_rise ? 1'b1 : hi);
      hi_drop = hi && !hi_nxt;
      lo_nxt  = (hi_drop || hit_loff) ? 1'b0 : (hit_len ? 1'b1 : lo);
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         hi <= 1'b0;
         lo <= 1'b0;
      end else begin
         hi <= hi_nxt;
         lo <= lo_nxt;
      end
   end

endmodule

// File: rtl/pwm_pair_gen.sv
`timescale 1ns/1ps
module pwm_pair_gen
   import pwm_pair_pkg::*;
#(
   parameter int NUM_PAIRS = 3,
   parameter int CNT_W     = 16,
   parameter int ADDR_W    = 4,
   parameter int SEL_W     = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [ADDR_W-1:0]    wr_addr,
   input  logic [CNT_W-1:0]     wr_data,
   output logic [NUM_PAIRS-1:0] pwm_hi,
   output logic [NUM_PAIRS-1:0] pwm_lo,
   output logic                 irq
);
   localparam int ADDR_CTRL = 0;
   localparam int ADDR_CLR  = 1 + FIELDS_PER_PAIR * NUM_PAIRS;
   localparam int ADDR_SPAN = ADDR_CLR + 1;

   generate
      if (NUM_PAIRS < 1 || NUM_PAIRS > 8) begin : g_bad_pairs
         $error("pwm_pair_gen: NUM_PAIRS must lie in 1..8");
      end
      if (CNT_W < CTRL_BITS) begin : g_bad_width
         $error("pwm_pair_gen: CNT_W too narrow for the control word");
      end
      if (ADDR_SPAN > (1 << ADDR_W)) begin : g_bad_addr
         $error("pwm_pair_gen: ADDR_W too narrow for the register map");
      end
      if (SEL_W != 3) begin : g_bad_sel
         $error("pwm_pair_gen: control word layout fixes SEL_W at 3");
      end
   endgenerate

   pwm_ctrl_t            ctrl;
   logic                 run;
   logic                 tick;
   logic                 clr_we;
   logic                 wrap_any;
   logic [NUM_PAIRS-1:0] wrap_vec;

   assign run    = ctrl.en && (ctrl.mode == MODE_STANDARD);
   assign clr_we = wr_en && (wr_addr == ADDR_W'(ADDR_CLR));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl <= '0;
      end else if (wr_en && (wr_addr == ADDR_W'(ADDR_CTRL))) begin
         ctrl <= pwm_ctrl_t'(wr_data[CTRL_BITS-1:0]);
      end
   end

   pwm_prescaler #(.SEL_W(SEL_W)) u_pre (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (run),
      .sel  (ctrl.sel),
      .tick (tick)
   );

   genvar p, f;
   generate
      for (p = 0; p < NUM_PAIRS; p++) begin : g_pair
         logic [FIELDS_PER_PAIR-1:0] fld_we;
         for (f = 0; f < FIELDS_PER_PAIR; f++) begin : g_dec
            assign fld_we[f] = wr_en &&
               (wr_addr == ADDR_W'(1 + FIELDS_PER_PAIR * p + f));
         end
         pwm_pair_core #(.CNT_W(CNT_W)) u_core (
            .clk    (clk),
            .rst_n  (rst_n),
            .run    (run),
            .tick   (tick),
            .fld_we (fld_we),
            .wr_data(wr_data),
            .hi     (pwm_hi[p]),
            .lo     (pwm_lo[p]),
            .wrap   (wrap_vec[p])
         );
      end
   endgenerate

   assign wrap_any = |wrap_vec;

   // A wrap in the same cycle as a clear keeps the flag set
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq <= 1'b0;
      end else if (wrap_any) begin
         irq <= 1'b1;
      end else if (clr_we) begin
         irq <= 1'b0;
      end
   end

endmodule

// File: rtl/pwm_pair_gen_chk.sv
`timescale 1ns/1ps
module pwm_pair_gen_chk #(
   parameter int NUM_PAIRS = 3
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 run,
   input logic                 clr_we,
   input logic                 wrap_any,
   input logic [NUM_PAIRS-1:0] pwm_hi,
   input logic [NUM_PAIRS-1:0] pwm_lo,
   input logic                 irq
);

   AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (pwm_hi == '0 && pwm_lo == '0)); // R2

   AST_LO_DROPS_WITH_HI: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(pwm_hi) & ~pwm_hi & pwm_lo) == '0)); // R6

   AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !clr_we) |=> irq); // R8

   AST_IRQ_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && !wrap_any) |=> !irq); // R8

   AST_IRQ_FROM_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(wrap_any)); // R8

   AST_WRAP_ONLY_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_any |-> run); // R3

endmodule

bind pwm_pair_gen pwm_pair_gen_chk #(.NUM_PAIRS(NUM_PAIRS)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .run     (run),
   .clr_we  (clr_we),
   .wrap_any(wrap_any),
   .pwm_hi  (pwm_hi),
   .pwm_lo  (pwm_lo),
   .irq     (irq)
);

// File: tb/pwm_pair_gen_tb.sv
`timescale 1ns/1ps
module pwm_pair_gen_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [2:0]  pwm_hi;
   logic [2:0]  pwm_lo;
   logic        irq;
   logic [5:0]  outs;
   int          cyc = 0;
   int          n_checks = 0;
   int          n_errors = 0;

   // Control encodings: sel in bits 2:0, mode bit 3 (1 = standard), enable bit 4
   localparam logic [15:0] CTL_OFF   = 16'h0000;
   localparam logic [15:0] CTL_RUN2  = 16'h0018;
   localparam logic [15:0] CTL_RUN16 = 16'h001B;
   localparam logic [15:0] CTL_RUN256= 16'h001F;
   localparam logic [15:0] CTL_BRIDGE= 16'h0010;
   localparam logic [15:0] CTL_STDOFF= 16'h0008;

   assign outs = {pwm_lo, pwm_hi};

   pwm_pair_gen u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo), .irq(irq)
   );

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic wr(input int addr, input logic [15:0] data);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 4'(addr); wr_data = data;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic cfg_pair(input int p, input int c0, input int c1, input int c2, input int len);
      wr(1 + 4*p, 16'(c0));
      wr(2 + 4*p, 16'(c1));
      wr(3 + 4*p, 16'(c2));
      wr(4 + 4*p, 16'(len));
   endtask

   // Waits at falling edges until outs[idx] has the level; returns the cycle count
   task automatic wait_lvl(input int idx, input logic lvl, output int t);
      int n = 0;
      while (outs[idx] !== lvl && n < 5000) begin
         @(negedge clk);
         n++;
      end
      if (n >= 5000) chk("R0", "edge timeout", 0, 1);
      t = cyc;
   endtask

   task automatic pulse_width(input int idx, output int w, output int t_rise);
      int t0, t1, t2;
      wait_lvl(idx, 1'b0, t0);
      wait_lvl(idx, 1'b1, t1);
      wait_lvl(idx, 1'b0, t2);
      w = t2 - t1;
      t_rise = t1;
   endtask

   task automatic t_reset();
      int bad = 0;
      repeat (10) begin
         @(negedge clk);
         if (outs !== 6'b0 || irq !== 1'b0) bad++;
      end
      chk("R1", "nonzero outputs after reset", bad, 0);
   endtask

   task automatic t_basic();
      int w, t1, t2, tmp;
      wr(0, CTL_OFF);
      cfg_pair(0, 2, 6, 1, 9);          // R10 pair 0 at 1..4, R7 taken while stopped
      wr(0, CTL_RUN2);
      pulse_width(0, w, t1);
      chk("R4", "pair0 high width", w, 8);
      wait_lvl(0, 1'b1, t2);
      chk("R3", "pair0 period div2", t2 - t1, 20);
      pulse_width(3, w, tmp);
      chk("R5", "pair0 low width", w, 4);
   endtask

   task automatic t_forced_low();
      int tr, tf, tmp;
      wr(0, CTL_OFF);
      cfg_pair(1, 1, 3, 8, 9);
      wr(0, CTL_RUN2);
      wait_lvl(4, 1'b0, tmp);
      wait_lvl(4, 1'b1, tr);
      wait_lvl(1, 1'b1, tmp);
      chk("R6", "low side still high while high side up", int'(pwm_lo[1]), 1);
      wait_lvl(4, 1'b0, tf);
      chk("R6", "high side low at low-side fall", int'(pwm_hi[1]), 0);
      wait_lvl(1, 1'b0, tmp);
      chk("R6", "both sides fall in one cycle", tmp, tf);
      chk("R6", "low width cut by high fall", tf - tr, 8);
   endtask

   task automatic t_independent();
      int w, t1, t2, u1, u2;
      wr(0, CTL_OFF);
      cfg_pair(2, 0, 2, 0, 4);
      wr(0, CTL_RUN2);
      pulse_width(2, w, u1);
      wait_lvl(2, 1'b1, u2);
      chk("R9", "pair2 period", u2 - u1, 10);
      chk("R9", "pair2 high width", w, 4);
      pulse_width(0, w, t1);
      wait_lvl(0, 1'b1, t2);
      chk("R9", "pair0 period unaffected", t2 - t1, 20);
   endtask

   task automatic t_prescale();
      int w, t1, t2;
      wr(0, CTL_OFF);
      cfg_pair(2, 0, 2, 0, 3);
      wr(0, CTL_RUN16);
      pulse_width(2, w, t1);
      wait_lvl(2, 1'b1, t2);
      chk("R3", "div16 period", t2 - t1, 64);
      chk("R4", "div16 high width", w, 32);
      wr(0, CTL_RUN256);
      pulse_width(2, w, t1);
      wait_lvl(2, 1'b1, t2);
      chk("R3", "div256 period", t2 - t1, 1024);
      chk("R4", "div256 high width", w, 512);
   endtask

   task automatic t_shadow();
      int ta, tb, tc, td, tmp;
      wr(0, CTL_OFF);
      cfg_pair(0, 2, 6, 1, 9);
      wr(0, CTL_RUN2);
      wait_lvl(0, 1'b0, tmp);
      wait_lvl(0, 1'b1, ta);
      wr(2, 16'd8);                     // R7 new compare 1 while running
      wait_lvl(0, 1'b0, tb);
      chk("R7", "current pulse keeps old compare", tb - ta, 8);
      wait_lvl(0, 1'b1, tc);
      wait_lvl(0, 1'b0, td);
      chk("R7", "next pulse uses new compare", td - tc, 12);
   endtask

   task automatic t_irq();
      int bad = 0;
      wr(0, CTL_OFF);
      repeat (50) @(negedge clk);
      chk("R8", "irq held after wraps", int'(irq), 1);
      wr(15, 16'hFFFF);
      chk("R10", "unused address leaves irq", int'(irq), 1);
      wr(14, 16'hFFFF);
      chk("R10", "unused address leaves irq", int'(irq), 1);
      wr(13, 16'h0000);
      chk("R8", "irq after clear", int'(irq), 0);
      wr(0, CTL_BRIDGE);
      repeat (300) begin
         @(negedge clk);
         if (outs !== 6'b0 || irq !== 1'b0) bad++;
      end
      chk("R2", "bridge mode outputs and irq", bad, 0);
      bad = 0;
      wr(0, CTL_STDOFF);
      repeat (300) begin
         @(negedge clk);
         if (outs !== 6'b0) bad++;
      end
      chk("R2", "standard mode disabled outputs", bad, 0);
      wr(0, CTL_RUN2);
      repeat (40) @(negedge clk);
      chk("R8", "irq set by wrap", int'(irq), 1);
      wr(0, CTL_OFF);
      @(negedge clk);
      chk("R2", "outputs low after stop", int'(outs), 0);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_basic();
      t_forced_low();
      t_independent();
      t_prescale();
      t_shadow();
      t_irq();
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule